// File: doc/BRIEF.md
# System Control Register Bank

This block is a memory-mapped bank of 32-bit system control words on a simple peripheral bus. The bus has a select strobe, a write flag, a byte address inside a 4 KB window, write data, registered read data and an error pulse. Software stores words in the bank and reads them back. A few status words always read back with two constant bits set. Those bits are added on the read path only and never change the stored value.

One control offset sits above the storage range. A full-word write of certain codes there makes a one-cycle system-reset request or a one-cycle shutdown request toward the power and reset logic, which is outside this block. Every access above the storage range sets the error pulse. A read there returns zero and a write there is not stored. This includes the control write, which is flagged as out of range even when it raises a request.

The bank resets synchronously to a set of fixed default words. Every access takes one bus cycle. Its result appears in the following cycle.

Top module: `sysreg_bank`

## Requirements
- R1: The word index is byte address bits [11:2]. A write with index 0 to 511 stores all 32 bits. A read there returns the word in the cycle after the select strobe, with busErr low. Index 511 is the last word stored.
- R2: After reset, word 0x40 is 0x05F20121, word 0x41 is 0x00000002, word 0x42 is 0x05F30121, word 0x43 is 0x05F40121, and every other word is 0.
- R3: A write of 1 or 2 to byte offset 0xF00 (word index 0x3C0) pulses resetReq high for exactly the one cycle after the write.
- R4: A write of 3 to offset 0xF00 pulses shutdownReq for one cycle. Any other value written there raises neither request. resetReq and shutdownReq are never high together.
- R5: A read with word index 512 or above returns 0 and pulses busErr in the cycle after the strobe. This includes offset 0xF00.
- R6: A write with word index 512 or above changes no stored word and pulses busErr in the cycle after the strobe. This includes the control write at 0xF00, whatever request it raises.
- R7: Reads of byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000. Offset 0x104 reads back unchanged. The forced bits are never written into storage.
- R8: Address bits [1:0] are ignored for storage, reads and the control write.
- R9: While rst is high, the bank loads its defaults, the request and error outputs are held low, and a control write in that cycle raises no request.
- R10: A write of a request code to an in-range offset raises no request and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busSel | input | 1 | Access strobe, one access per cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address inside the 4 KB window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busErr | output | 1 | Out-of-range pulse, aligned with the response |
| resetReq | output | 1 | One-cycle system-reset request |
| shutdownReq | output | 1 | One-cycle shutdown request |

## Verification
The bench builds the bank with its default parameters: a 12-bit address, 512 words and the control offset at word index 0x3C0. With these values, the last stored word (511) and the first out-of-range word (512) can both be reached. The control offset also falls inside the range that errors, so one write exercises a request and a dropped store together. The bench checks the three forced-bit words next to the unforced word at 0x104. It also drives a control write while reset is asserted, to confirm that reset wins over the request.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

  // Strobes from control to datapath for the current access
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic inRange;
    logic forceHi;
  } sysregStrobeT;

  localparam logic [31:0] FORCE_MASK = 32'h3000_0000;
  localparam int          ID_WORD_A  = 'h40;
  localparam int          ID_WORD_B  = 'h41;
  localparam int          ID_WORD_C  = 'h42;
  localparam int          ID_WORD_D  = 'h43;
  localparam logic [31:0] CODE_RST_A = 32'd1;
  localparam logic [31:0] CODE_RST_B = 32'd2;
  localparam logic [31:0] CODE_OFF   = 32'd3;

  function automatic logic [31:0] resetWord(input int idx);
    case (idx)
      ID_WORD_A: resetWord = 32'h05F2_0121;
      ID_WORD_B: resetWord = 32'h0000_0002;
      ID_WORD_C: resetWord = 32'h05F3_0121;
      ID_WORD_D: resetWord = 32'h05F4_0121;
      default:   resetWord = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
  import sysreg_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 512,
  parameter int CTRL_IDX  = 'h3C0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output sysregStrobeT        st,
  output logic [ADDR_W-3:0]   wordIdx,
  output logic                busErr,
  output logic                resetReq,
  output logic                shutdownReq
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W:0]   LIMIT   = NUM_WORDS[IDX_W:0];
  localparam logic [IDX_W-1:0] CTRL_AT = CTRL_IDX[IDX_W-1:0];

  logic ctrlHit;
  logic isRstCode;
  logic isOffCode;

  always_comb begin
    wordIdx    = busAddr[ADDR_W-1:2];
    st.inRange = ({1'b0, wordIdx} < LIMIT);
    st.wrEn    = busSel && busWrite;
    st.rdEn    = busSel && !busWrite;
    st.forceHi = (wordIdx == IDX_W'(ID_WORD_A)) ||
                 (wordIdx == IDX_W'(ID_WORD_C)) ||
                 (wordIdx == IDX_W'(ID_WORD_D));
    ctrlHit    = st.wrEn && (wordIdx == CTRL_AT);
    isRstCode  = (busWdata == CODE_RST_A) || (busWdata == CODE_RST_B);
    isOffCode  = (busWdata == CODE_OFF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busErr      <= 1'b0;
      resetReq    <= 1'b0;
      shutdownReq <= 1'b0;
    end else begin
      busErr      <= busSel && !st.inRange;
      resetReq    <= ctrlHit && isRstCode;
      shutdownReq <= ctrlHit && isOffCode;
    end
  end

  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (rst)
    resetReq |-> $past(busSel && busWrite && busAddr[ADDR_W-1:2] == CTRL_AT &&
                       (busWdata == 32'd1 || busWdata == 32'd2))); // R3

  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    shutdownReq |-> $past(busSel && busWrite && busAddr[ADDR_W-1:2] == CTRL_AT &&
                          busWdata == 32'd3)); // R4

  AST_REQ_MUTEX: assert property (@(posedge clk) disable iff (rst)
    !(resetReq && shutdownReq)); // R4

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    busErr |-> $past(busSel && {1'b0, busAddr[ADDR_W-1:2]} >= LIMIT)); // R5
endmodule

// File: rtl/sysreg_data.sv
module sysreg_data
  import sysreg_pkg::*;
#(
  parameter int NUM_WORDS = 512,
  parameter int MEM_AW    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  sysregStrobeT      st,
  input  logic [MEM_AW-1:0] memIdx,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData
);
  logic [31:0] words [NUM_WORDS];

  // One register per word, each with its own reset value
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        words[g] <= resetWord(g);
      else if (st.wrEn && st.inRange && memIdx == MEM_AW'(g))
        words[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdData <= '0;
    else if (st.rdEn)
      rdData <= st.inRange ? (words[memIdx] | (st.forceHi ? FORCE_MASK : 32'h0))
                           : 32'h0;
  end

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && st.rdEn && !st.inRange) |-> rdData == 32'h0); // R5

  AST_FORCE_BITS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && st.rdEn && st.inRange && st.forceHi) |->
      (rdData & FORCE_MASK) == FORCE_MASK); // R7

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !st.rdEn) |-> $stable(rdData)); // R1
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_WORDS = 512,
  parameter int CTRL_IDX  = 'h3C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  output logic              resetReq,
  output logic              shutdownReq
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int MEM_AW = $clog2(NUM_WORDS);

  sysregStrobeT     st;
  logic [IDX_W-1:0] wordIdx;

  sysreg_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .CTRL_IDX(CTRL_IDX)
  ) u_ctrl (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .st(st), .wordIdx(wordIdx),
    .busErr(busErr), .resetReq(resetReq), .shutdownReq(shutdownReq)
  );

  sysreg_data #(
    .NUM_WORDS(NUM_WORDS), .MEM_AW(MEM_AW)
  ) u_data (
    .clk(clk), .rst(rst), .st(st), .memIdx(wordIdx[MEM_AW-1:0]),
    .wrData(busWdata), .rdData(busRdata)
  );
endmodule

// File: tb/tb_sysreg_bank.sv
`timescale 1ns/1ps
module tb_sysreg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr, resetReq, shutdownReq;

  always #2 clk = ~clk; // 250 MHz

  sysreg_bank dut (
    .clk(clk), .rst(rst), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busErr(busErr), .resetReq(resetReq), .shutdownReq(shutdownReq)
  );

  typedef struct packed {
    logic        chkRd;
    logic [31:0] rd;
    logic        err;
    logic        rq;
    logic        off;
  } expT;

  expT   expQ[$];
  string tagQ[$];
  int    checkCnt = 0;
  int    failCnt  = 0;
  bit    done     = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d,
                         input bit eErr, input bit eRst, input bit eOff,
                         input string tag);
    expT e;
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    e = '{chkRd: 1'b0, rd: 32'h0, err: eErr, rq: eRst, off: eOff};
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic doRead(input logic [11:0] a, input logic [31:0] d,
                        input bit eErr, input string tag);
    expT e;
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    e = '{chkRd: 1'b1, rd: d, err: eErr, rq: 1'b0, off: 1'b0};
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    busSel = 0;
  endtask

  // Monitor: response appears one edge after the strobe
  always @(posedge clk) begin
    bit sawSel, sawRst;
    expT e;
    string t;
    sawSel = busSel;
    sawRst = rst;
    #1;
    if (!sawRst && !done) begin
      if (sawSel) begin
        if (expQ.size() == 0) begin
          check(1'b0, "scoreboard empty", 32'h0, 32'h1);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (e.chkRd) check(busRdata == e.rd, t, busRdata, e.rd);
          check(busErr == e.err, {t, " err"}, 32'(busErr), 32'(e.err));
          check(resetReq == e.rq, {t, " resetReq"}, 32'(resetReq), 32'(e.rq));
          check(shutdownReq == e.off, {t, " shutdownReq"}, 32'(shutdownReq), 32'(e.off));
        end
      end else begin
        check({busErr, resetReq, shutdownReq} == 3'b000, "R3 idle pulses low",
              32'({busErr, resetReq, shutdownReq}), 32'h0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busErr, resetReq, shutdownReq, busRdata} == 35'h0, "R9 outputs in reset",
          busRdata, 32'h0);
    rst = 0;

    // R2 / R7 defaults and forced bits
    doRead(12'h100, 32'h35F2_0121, 0, "R2 R7 word 0x40");
    doRead(12'h104, 32'h0000_0002, 0, "R2 R7 word 0x41 unforced");
    doRead(12'h108, 32'h35F3_0121, 0, "R2 R7 word 0x42");
    doRead(12'h10C, 32'h35F4_0121, 0, "R2 R7 word 0x43");
    doRead(12'h000, 32'h0, 0, "R2 word 0");
    doRead(12'h7FC, 32'h0, 0, "R2 word 511");

    // R1 storage and boundary
    doWrite(12'h000, 32'hA5A5_5A5A, 0, 0, 0, "R1 write word 0");
    doRead(12'h000, 32'hA5A5_5A5A, 0, "R1 read word 0");
    doWrite(12'h7FC, 32'hDEAD_BEEF, 0, 0, 0, "R1 write word 511");
    doRead(12'h7FC, 32'hDEAD_BEEF, 0, "R1 read word 511");

    // R5 / R6 out of range
    doWrite(12'h800, 32'h1111_2222, 1, 0, 0, "R6 write word 512");
    doRead(12'h800, 32'h0, 1, "R5 read word 512");
    doRead(12'hFFC, 32'h0, 1, "R5 read last index");
    doRead(12'h000, 32'hA5A5_5A5A, 0, "R6 word 0 not aliased");
    doRead(12'h7FC, 32'hDEAD_BEEF, 0, "R6 word 511 kept");

    // R7 forced bits on read path only
    doWrite(12'h100, 32'h0, 0, 0, 0, "R7 write 0x100");
    doRead(12'h100, 32'h3000_0000, 0, "R7 forced on zero");
    doWrite(12'h100, 32'hC000_000F, 0, 0, 0, "R7 write 0x100 pattern");
    doRead(12'h100, 32'hF000_000F, 0, "R7 forced OR pattern");
    doWrite(12'h104, 32'hFFFF_0000, 0, 0, 0, "R7 write 0x104");
    doRead(12'h104, 32'hFFFF_0000, 0, "R7 0x104 raw");
    doWrite(12'h10C, 32'h0000_0001, 0, 0, 0, "R7 write 0x10C");
    doRead(12'h10C, 32'h3000_0001, 0, "R7 0x10C forced");

    // R8 low address bits ignored
    doWrite(12'h013, 32'h0000_1234, 0, 0, 0, "R8 write unaligned");
    doRead(12'h010, 32'h0000_1234, 0, "R8 aligned read");
    doRead(12'h011, 32'h0000_1234, 0, "R8 unaligned read");

    // R3 / R4 / R6 control writes
    doWrite(12'hF00, 32'd1, 1, 1, 0, "R3 code 1");
    doWrite(12'hF00, 32'd2, 1, 1, 0, "R3 code 2");
    doWrite(12'hF00, 32'd3, 1, 0, 1, "R4 code 3");
    doWrite(12'hF00, 32'd0, 1, 0, 0, "R4 code 0");
    doWrite(12'hF00, 32'd4, 1, 0, 0, "R4 code 4");
    doWrite(12'hF00, 32'h1_0001, 1, 0, 0, "R4 code high bits");
    doWrite(12'hF03, 32'd1, 1, 1, 0, "R8 control unaligned");
    doRead(12'hF00, 32'h0, 1, "R5 read control offset");
    doWrite(12'hF04, 32'd1, 1, 0, 0, "R6 neighbour of control");

    // R10 code written in range
    doWrite(12'h040, 32'd1, 0, 0, 0, "R10 code 1 in range");
    doWrite(12'h044, 32'd3, 0, 0, 0, "R10 code 3 in range");
    doRead(12'h040, 32'd1, 0, "R10 stored");

    // R9 reset wins over control write, then defaults return
    @(negedge clk);
    rst = 1; busSel = 1; busWrite = 1; busAddr = 12'hF00; busWdata = 32'd3;
    @(negedge clk);
    check(!shutdownReq && !resetReq, "R9 request blocked by reset",
          32'({resetReq, shutdownReq}), 32'h0);
    busSel = 0; busWrite = 0;
    @(negedge clk);
    check(!shutdownReq && !busErr, "R9 no late request", 32'(shutdownReq), 32'h0);
    rst = 0;
    doRead(12'h000, 32'h0, 0, "R9 word 0 back to default");
    doRead(12'h100, 32'h35F2_0121, 0, "R9 word 0x40 back to default");
    doRead(12'h7FC, 32'h0, 0, "R9 word 511 back to default");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", 32'(expQ.size()), 32'h0);
    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule